// File: doc/BRIEF.md
# Packed Rounding Average Unit

This block takes two 64-bit operands and splits both into lanes of equal width, either eight 8-bit lanes or four 16-bit lanes. A mode input picks the width on each transaction. In every lane it forms the unsigned average of the two inputs and rounds a half upward. The lanes share one datapath but never affect each other.

The arithmetic is combinational and feeds one output register stage. The caller raises `in_valid` with the operands and the mode. The result appears on `out_data` one clock later, with `out_valid` high. The operation never overflows and never saturates, so the block has no status flags.

Top module: `packed_avg_unit`

## Requirements
- R1: A synchronous active-high `rst` clears `out_valid` and `out_data` to zero at the next rising clock edge.
- R2: `out_valid` at clock edge n+1 equals the `in_valid` value sampled at clock edge n.
- R3: With `in_mode` = 0, result bits [8i+7:8i] (i = 0..7, lane 0 in the least significant bits) equal (a_i + b_i + 1) >> 1. The sum is formed in 9 bits on unsigned operands, so the carry becomes bit 7 of the lane.
- R4: With `in_mode` = 1, result bits [16i+15:16i] (i = 0..3) equal (a_i + b_i + 1) >> 1. The sum is formed in 17 bits on unsigned operands.
- R5: No carry passes from one lane into the next in either mode. With all-ones operands the result is all ones.
- R6: An odd lane sum rounds up. A lane holding 0 averaged with a lane holding 1 gives 1.
- R7: Equal operands in a lane give that operand back. Two zero lanes give zero.
- R8: `in_mode` and the operands are captured only when `in_valid` is high. While `in_valid` is low, `out_data` keeps its previous value.
- R9: Each lane result lies between the smaller and the larger of its two inputs, inclusive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and mode are valid |
| in_mode | input | 1 | Lane width: 0 = 8-bit lanes, 1 = 16-bit lanes |
| in_a | input | 64 | First packed operand |
| in_b | input | 64 | Second packed operand |
| out_valid | output | 1 | Result is valid, one clock after `in_valid` |
| out_data | output | 64 | Packed rounded averages |

## Verification
The bench aims at the lane carry. All-ones operands expose a design that drops the ninth or seventeenth sum bit, because that design returns 0x7F or 0x7FFF lanes instead of all ones. The same operands expose a design that lets a carry cross into the neighbouring lane, because the low bits of the next lane come out wrong. The pair 0 and 1 exposes truncating rounding, which gives 0 instead of 1. Word-mode patterns whose bytes differ expose a mode decode that is inverted or ignored. Cycles with `in_valid` low and changed operands expose a register that loads regardless of `in_valid`.

// File: rtl/pavg_pkg.sv
package pavg_pkg;

    localparam int DATA_W   = 64;
    localparam int NARROW_W = 8;
    localparam int WIDE_W   = 16;
    localparam int NARROW_N = DATA_W / NARROW_W;
    localparam int WIDE_N   = DATA_W / WIDE_W;

    typedef logic [DATA_W-1:0] vec_t;

    typedef enum logic {
        LANES_NARROW = 1'b0,
        LANES_WIDE   = 1'b1
    } lane_mode_e;

    typedef struct packed {
        lane_mode_e mode;
        vec_t       a;
        vec_t       b;
    } avg_req_t;

endpackage

// File: rtl/avg_lane.sv
module avg_lane #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] avg
);
    localparam int SUM_W = W + 1;

    logic [SUM_W-1:0] sum_ext;

    // The extra bit keeps the carry; the shift drops it into the MSB (R3, R4).
    always_comb begin
        sum_ext = {1'b0, a} + {1'b0, b} + SUM_W'(1);
        avg     = sum_ext[SUM_W-1:1];
    end

    // R9: the average lies between its inputs.
    always_comb begin
        a_r9_between_inputs: assert ((avg >= ((a < b) ? a : b)) && (avg <= ((a < b) ? b : a)));
    end

endmodule

// File: rtl/avg_datapath.sv
module avg_datapath
    import pavg_pkg::*;
(
    input  avg_req_t req,
    output vec_t     res
);
    vec_t res_narrow;
    vec_t res_wide;

    // Eight independent byte lanes (R3, R5).
    for (genvar i = 0; i < NARROW_N; i++) begin : g_narrow
        avg_lane #(.W(NARROW_W)) u_lane (
            .a   (req.a[i*NARROW_W +: NARROW_W]),
            .b   (req.b[i*NARROW_W +: NARROW_W]),
            .avg (res_narrow[i*NARROW_W +: NARROW_W])
        );
    end

    // Four independent 16-bit lanes (R4, R5).
    for (genvar j = 0; j < WIDE_N; j++) begin : g_wide
        avg_lane #(.W(WIDE_W)) u_lane (
            .a   (req.a[j*WIDE_W +: WIDE_W]),
            .b   (req.b[j*WIDE_W +: WIDE_W]),
            .avg (res_wide[j*WIDE_W +: WIDE_W])
        );
    end

    always_comb begin
        res = (req.mode == LANES_WIDE) ? res_wide : res_narrow;
    end

    // R7: equal operands come back unchanged in either mode.
    always_comb begin
        a_r7_equal_operands: assert ((req.a != req.b) || (res == req.a));
    end

endmodule

// File: rtl/packed_avg_unit.sv
module packed_avg_unit
    import pavg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic        in_mode,
    input  logic [63:0] in_a,
    input  logic [63:0] in_b,
    output logic        out_valid,
    output logic [63:0] out_data
);
    avg_req_t req;
    vec_t     comb_res;

    always_comb begin
        req.mode = lane_mode_e'(in_mode);
        req.a    = in_a;
        req.b    = in_b;
    end

    avg_datapath u_datapath (
        .req (req),
        .res (comb_res)
    );

    // R1, R2, R8: single output stage, loads only on in_valid.
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_data <= comb_res;
            end
        end
    end

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r2_idle_follows: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_data));

endmodule

// File: tb/packed_avg_unit_tb.sv
module packed_avg_unit_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_mode = 1'b0;
    logic [63:0] in_a = '0;
    logic [63:0] in_b = '0;
    logic        out_valid;
    logic [63:0] out_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    packed_avg_unit u_dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_mode   (in_mode),
        .in_a      (in_a),
        .in_b      (in_b),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    function automatic logic [63:0] ref_avg(input logic [63:0] a, input logic [63:0] b,
                                            input logic mode);
        int w;
        logic [63:0] r;
        w = mode ? 16 : 8;
        r = '0;
        for (int i = 0; i < 64 / w; i++) begin
            longint unsigned m, x, y, s;
            m = (64'd1 << w) - 1;
            x = (a >> (i * w)) & m;
            y = (b >> (i * w)) & m;
            s = ((x + y + 1) >> 1) & m;
            r = r | (s << (i * w));
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    logic [63:0] last_exp = '0;

    task automatic apply(input string req, input logic [63:0] a, input logic [63:0] b,
                         input logic mode);
        @(negedge clk);
        in_valid = 1'b1;
        in_mode  = mode;
        in_a     = a;
        in_b     = b;
        @(posedge clk);
        #1;
        last_exp = ref_avg(a, b, mode);
        check({req, " valid"}, {63'd0, out_valid}, 64'd1);
        check(req, out_data, last_exp);
    endtask

    task automatic idle_cycle(input logic [63:0] a, input logic [63:0] b, input logic mode);
        @(negedge clk);
        in_valid = 1'b0;
        in_mode  = mode;
        in_a     = a;
        in_b     = b;
        @(posedge clk);
        #1;
        check("R2 valid drops", {63'd0, out_valid}, 64'd0);
        check("R8 hold", out_data, last_exp);
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset valid", {63'd0, out_valid}, 64'd0);
        check("R1 reset data", out_data, 64'd0);
        @(negedge clk);
        rst = 1'b0;

        // R5 all ones, both modes
        apply("R5 ones narrow", '1, '1, 1'b0);
        check("R5 ones narrow literal", out_data, 64'hFFFF_FFFF_FFFF_FFFF);
        apply("R5 ones wide", '1, '1, 1'b1);
        apply("R5 carry isolation narrow", 64'hFF00_FF00_FF00_FF00, 64'hFF01_FF01_FF01_FF01, 1'b0);
        apply("R5 carry isolation wide", 64'hFFFF_0001_FFFF_0001, 64'hFFFF_0000_FFFF_0000, 1'b1);
        // R7 zeros
        apply("R7 zeros narrow", '0, '0, 1'b0);
        apply("R7 zeros wide", '0, '0, 1'b1);
        apply("R7 equal wide", 64'h1234_ABCD_8000_7FFF, 64'h1234_ABCD_8000_7FFF, 1'b1);
        // R6 rounding up
        apply("R6 zero-one narrow", 64'h0, 64'h0101_0101_0101_0101, 1'b0);
        check("R6 zero-one narrow literal", out_data, 64'h0101_0101_0101_0101);
        apply("R6 zero-one wide", 64'h0001_0001_0001_0001, 64'h0, 1'b1);
        check("R6 zero-one wide literal", out_data, 64'h0001_0001_0001_0001);
        // R3 vs R4 mode decode with carry between bytes
        apply("R3 narrow mode", 64'h00FF_00FF_80FF_0180, 64'h0001_0001_80FF_0080, 1'b0);
        apply("R4 wide mode", 64'h00FF_00FF_80FF_0180, 64'h0001_0001_80FF_0080, 1'b1);
        check("R4 wide literal", out_data, 64'h0080_0080_80FF_0100);
        // R8 idle cycles with changed inputs
        idle_cycle('1, 64'h0, 1'b1);
        idle_cycle(64'h5555, 64'hAAAA, 1'b0);

        // Random mix (R3, R4, R9)
        for (int k = 0; k < 300; k++) begin
            logic [63:0] ra, rb;
            logic rm;
            ra = {$urandom, $urandom};
            rb = {$urandom, $urandom};
            rm = $urandom[0];
            apply(rm ? "R4 random" : "R3 random", ra, rb, rm);
            if ((k % 37) == 0) idle_cycle(rb, ra, ~rm);
        end

        // R1 reset mid-stream
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b1;
        @(posedge clk);
        #1;
        check("R1 reset valid late", {63'd0, out_valid}, 64'd0);
        check("R1 reset data late", out_data, 64'd0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule